// File: doc/BRIEF.md
# Two-Tier Round-Robin Transmit DMA Arbiter

This block decides which of six transmit FIFOs, one for each IN endpoint, receives DMA service next. A FIFO competes only while its request queue holds work and the FIFO has room for more data. A software-writable priority register places each FIFO in a high or a low tier. Eligible high-tier FIFOs are served in round-robin order. The low tier is served, also in round-robin order, only in a decision where no high-tier FIFO is eligible.

The grant covers one packet. Once a FIFO has been granted, the grant stays with it through every piece of that packet, including the pieces of a scatter-gather packet. The grant is released only when the DMA engine raises packet-done. Each tier has its own rotation pointer. When a packet ends, the pointer of the tier that won that packet moves to the index just after the finishing FIFO.

The timing is fixed. A decision is taken in a cycle where no packet is in progress, and the grant appears on the output after the next clock edge. After the clock edge that samples packet-done, the grant reads zero for one cycle; the next decision is taken in that cycle. Priority writes made during a packet are used from the next decision onward.

Top module: `txdma_tier_arb`

## Requirements
- R1: After reset the priority register reads 0, so every FIFO is in the low tier; `grant` is 0, `grant_valid` is 0, and both tier pointers point at FIFO 0.
- R2: A write on `cfg_wr_en` stores `cfg_wr_data[5:0]` as the priority bits, where bit n belongs to FIFO n. `cfg_rd_data` returns these bits in [5:0] from the cycle after the write. Bits [31:6] always read as 0, and any value written to them has no effect.
- R3: FIFO n is eligible only when `req_pending[n]` and `fifo_room[n]` are both 1. A FIFO that is not eligible is never granted.
- R4: When priority bit n is 1, FIFO n is in the high tier. If any high-tier FIFO is eligible in a decision cycle, the winner is a high-tier FIFO.
- R5: When priority bit n is 0, FIFO n is in the low tier. A low-tier FIFO wins only in a decision cycle where no high-tier FIFO is eligible.
- R6: Within a tier, the winner is the first eligible FIFO of that tier found by searching upward from that tier's pointer, wrapping from 5 to 0. When a packet ends, the winning tier's pointer becomes (owner+1) mod 6. The other tier's pointer does not change.
- R7: While a packet is in progress, `grant` and `grant_valid` stay constant until `pkt_done` is sampled. This holds even if the eligibility inputs change, and it covers multi-piece scatter-gather packets.
- R8: A decision is taken in any cycle with no packet in progress and at least one eligible FIFO; the grant appears after the next edge. After the edge that samples `pkt_done` during a packet, `grant` is 0 for one cycle.
- R9: `grant` is one-hot or zero, and `grant_valid` equals the OR of its bits. When nothing is eligible and no packet is in progress, `grant` is 0.
- R10: A priority write during a packet does not change the current grant. The new value is used from the next decision onward. The pointer that advances is the pointer of the tier in which the packet was won.
- R11: `pkt_done` while no packet is in progress has no effect on the grant or on either pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Priority register write strobe |
| cfg_wr_data | input | 32 | Priority register write data |
| cfg_rd_data | output | 32 | Priority register read data |
| req_pending | input | 6 | Per-FIFO request queue non-empty |
| fifo_room | input | 6 | Per-FIFO space available |
| pkt_done | input | 1 | Current packet completed |
| grant | output | 6 | One-hot grant of the packet owner |
| grant_valid | output | 1 | A packet grant is active |

## Verification
The hardest situation to reach from the ports is a packet whose tier changes while the packet is in progress. To check it, a priority write must land during the lock, and the pointer update must then be traced to the tier in which the packet was won rather than the tier the FIFO now belongs to. A directed sequence arranges exactly that case and then steps both pointers around their wrap points. A long random phase follows. In that phase, priority writes, pulses of `pkt_done` while idle, and changes of eligibility during a packet all occur freely, and a behavioural model is compared against the design on every clock.

// File: rtl/txarb_pkg.sv
package txarb_pkg;
  localparam int TIER_LOW  = 0;
  localparam int TIER_HIGH = 1;

  // Index that follows idx in a ring of n entries.
  function automatic int ring_next(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // Offset position k places past base, wrapped into a ring of n.
  function automatic int ring_add(input int base, input int k, input int n);
    int s;
    s = base + k;
    if (s >= n) s = s - n;
    return s;
  endfunction
endpackage

// File: rtl/txarb_prio_reg.sv
module txarb_prio_reg #(
  parameter int NUM_REQ = 6,
  parameter int REG_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [NUM_REQ-1:0] prio,
  output logic [REG_W-1:0]   rd_data
);
  localparam int PAD_W = REG_W - NUM_REQ;

  logic unused_hi_bits;
  assign unused_hi_bits = ^wr_data[REG_W-1:NUM_REQ];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     prio <= '0;
    else if (wr_en) prio <= wr_data[NUM_REQ-1:0];
  end

  assign rd_data = {{PAD_W{1'b0}}, prio};
endmodule

// File: rtl/txarb_rr_pick.sv
module txarb_rr_pick
  import txarb_pkg::*;
#(
  parameter int NUM_REQ = 6,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_REQ-1:0] mask,
  input  logic [IDX_W-1:0]   start,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  logic [IDX_W-1:0] cand;

  // Scan from the far end so that the nearest hit to start is written last.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    cand  = '0;
    for (int k = NUM_REQ - 1; k >= 0; k--) begin
      cand = IDX_W'(ring_add(int'(start), k, NUM_REQ));
      if (mask[cand]) begin
        found = 1'b1;
        idx   = cand;
      end
    end
  end
endmodule

// File: rtl/txdma_tier_arb.sv
module txdma_tier_arb
  import txarb_pkg::*;
#(
  parameter int NUM_REQ = 6,
  parameter int REG_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [REG_W-1:0]   cfg_wr_data,
  output logic [REG_W-1:0]   cfg_rd_data,
  input  logic [NUM_REQ-1:0] req_pending,
  input  logic [NUM_REQ-1:0] fifo_room,
  input  logic               pkt_done,
  output logic [NUM_REQ-1:0] grant,
  output logic               grant_valid
);
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
  localparam int TIERS  = 2;

  logic [NUM_REQ-1:0] prio_q;
  logic [NUM_REQ-1:0] elig_w;
  logic [NUM_REQ-1:0] tier_mask [TIERS];
  logic [IDX_W-1:0]   ptr_q     [TIERS];
  logic [IDX_W-1:0]   pick_idx  [TIERS];
  logic               pick_hit  [TIERS];

  logic               busy_q;
  logic [IDX_W-1:0]   owner_q;
  logic               owner_tier_q;

  logic               dec_fire;
  logic               rel_fire;
  logic               win_tier;
  logic [IDX_W-1:0]   win_idx;

  txarb_prio_reg #(.NUM_REQ(NUM_REQ), .REG_W(REG_W)) u_prio (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .prio    (prio_q),
    .rd_data (cfg_rd_data)
  );

  assign elig_w               = req_pending & fifo_room;
  assign tier_mask[TIER_HIGH] = elig_w & prio_q;
  assign tier_mask[TIER_LOW]  = elig_w & ~prio_q;

  for (genvar t = 0; t < TIERS; t++) begin : g_tier
    txarb_rr_pick #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_pick (
      .mask  (tier_mask[t]),
      .start (ptr_q[t]),
      .found (pick_hit[t]),
      .idx   (pick_idx[t])
    );
  end

  // High tier wins whenever it has any eligible member.
  assign win_tier = pick_hit[TIER_HIGH];
  assign win_idx  = win_tier ? pick_idx[TIER_HIGH] : pick_idx[TIER_LOW];
  assign dec_fire = !busy_q && (pick_hit[TIER_HIGH] || pick_hit[TIER_LOW]);
  assign rel_fire = busy_q && pkt_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      owner_q      <= '0;
      owner_tier_q <= 1'b0;
      for (int t = 0; t < TIERS; t++) ptr_q[t] <= '0;
    end else if (dec_fire) begin
      busy_q       <= 1'b1;
      owner_q      <= win_idx;
      owner_tier_q <= win_tier;
    end else if (rel_fire) begin
      busy_q                <= 1'b0;
      ptr_q[owner_tier_q]   <= IDX_W'(ring_next(int'(owner_q), NUM_REQ));
    end
  end

  assign grant       = busy_q ? ({{(NUM_REQ-1){1'b0}}, 1'b1} << owner_q) : '0;
  assign grant_valid = busy_q;
endmodule

// File: rtl/txarb_checker.sv
module txarb_checker #(
  parameter int NUM_REQ = 6,
  parameter int REG_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [REG_W-1:0]   cfg_rd_data,
  input logic [NUM_REQ-1:0] grant,
  input logic               grant_valid,
  input logic               pkt_done,
  input logic [NUM_REQ-1:0] elig,
  input logic [NUM_REQ-1:0] prio,
  input logic               dec_fire
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[REG_W-1:NUM_REQ] == '0); // R2

  AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire |=> |(grant & $past(elig))); // R3

  AST_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire && |(elig & prio) |=> |(grant & $past(prio))); // R4

  AST_LOW_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire && !(|(elig & prio)) |=> |(grant & ~$past(prio))); // R5

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && !pkt_done |=> grant_valid && $stable(grant)); // R7

  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && pkt_done |=> !grant_valid); // R8

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (grant_valid == (|grant))); // R9
endmodule

bind txdma_tier_arb txarb_checker #(.NUM_REQ(NUM_REQ), .REG_W(REG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_rd_data (cfg_rd_data),
  .grant       (grant),
  .grant_valid (grant_valid),
  .pkt_done    (pkt_done),
  .elig        (elig_w),
  .prio        (prio_q),
  .dec_fire    (dec_fire)
);

// File: tb/txdma_tier_arb_test.sv
module txdma_tier_arb_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREQ       = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic [5:0]  req_pending = '0;
  logic [5:0]  fifo_room = '0;
  logic        pkt_done = 1'b0;
  logic [5:0]  grant;
  logic        grant_valid;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  bit         m_busy;
  int         m_owner;
  int         m_tier;
  int         m_ptr [2];
  logic [5:0] m_prio;

  always #(CLK_PERIOD/2) clk = ~clk;

  txdma_tier_arb uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .req_pending(req_pending), .fifo_room(fifo_room),
    .pkt_done(pkt_done), .grant(grant), .grant_valid(grant_valid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int first_from(input logic [5:0] m, input int start);
    for (int k = 0; k < NREQ; k++)
      if (m[(start + k) % NREQ]) return (start + k) % NREQ;
    return -1;
  endfunction

  function automatic logic [5:0] m_grant();
    return m_busy ? 6'(1 << m_owner) : 6'h00;
  endfunction

  task automatic model_edge(input bit we, input logic [31:0] wd,
                            input logic [5:0] rq, input logic [5:0] rm, input bit dn);
    logic [5:0] e, hi, lo;
    e  = rq & rm;
    hi = e & m_prio;
    lo = e & ~m_prio;
    if (m_busy) begin
      if (dn) begin
        m_busy = 0;
        m_ptr[m_tier] = (m_owner + 1) % NREQ;
      end
    end else if (hi != 0) begin
      m_owner = first_from(hi, m_ptr[1]); m_tier = 1; m_busy = 1;
    end else if (lo != 0) begin
      m_owner = first_from(lo, m_ptr[0]); m_tier = 0; m_busy = 1;
    end
    if (we) m_prio = wd[5:0];
  endtask

  // Drive one cycle of inputs at a falling edge, then compare at the next one.
  task automatic cyc(input string tag, input bit we, input logic [31:0] wd,
                     input logic [5:0] rq, input logic [5:0] rm, input bit dn);
    cfg_wr_en = we; cfg_wr_data = wd; req_pending = rq; fifo_room = rm; pkt_done = dn;
    model_edge(we, wd, rq, rm, dn);
    @(negedge clk);
    chk({tag, " grant"}, 32'(grant), 32'(m_grant()));
    chk({tag, " valid"}, 32'(grant_valid), 32'(m_busy));
    chk({tag, " rdata"}, cfg_rd_data, {26'd0, m_prio});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_busy = 0; m_owner = 0; m_tier = 0; m_ptr[0] = 0; m_ptr[1] = 0; m_prio = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 grant", 32'(grant), 32'h0);
    chk("R1 valid", 32'(grant_valid), 32'h0);
    chk("R1 rdata", cfg_rd_data, 32'h0);

    // R2: reserved bits discarded, FIFOs 1,3,5 high
    cyc("R2", 1, 32'hFFFF_FFEA, 6'h00, 6'h00, 0);
    chk("R2 readback", cfg_rd_data, 32'h0000_002A);

    // R3: only FIFO0 has room
    cyc("R3", 0, 0, 6'h3F, 6'h01, 0);
    chk("R3 only eligible wins", 32'(grant), 32'h01);
    // R7: eligibility vanishes mid packet, grant held
    for (int i = 0; i < 3; i++) cyc("R7", 0, 0, 6'h00, 6'h00, 0);
    chk("R7 grant held", 32'(grant), 32'h01);
    cyc("R8", 0, 0, 6'h00, 6'h00, 1);
    chk("R8 gap after done", 32'(grant), 32'h00);

    // R4/R6: high tier rotation 1 -> 3 -> 5 -> 1
    cyc("R4", 0, 0, 6'h3F, 6'h3F, 0);
    chk("R4 high tier first", 32'(grant), 32'h02);
    cyc("R6", 0, 0, 6'h3F, 6'h3F, 1);
    cyc("R6", 0, 0, 6'h3F, 6'h3F, 0);
    chk("R6 high rotate", 32'(grant), 32'h08);
    cyc("R6", 0, 0, 6'h3F, 6'h3F, 1);
    cyc("R6", 0, 0, 6'h3F, 6'h3F, 0);
    chk("R6 high rotate", 32'(grant), 32'h20);
    cyc("R6", 0, 0, 6'h3F, 6'h3F, 1);
    cyc("R6", 0, 0, 6'h3F, 6'h3F, 0);
    chk("R6 high wrap", 32'(grant), 32'h02);
    cyc("R6", 0, 0, 6'h3F, 6'h3F, 1);

    // R5: low tier only, pointer at 1 after FIFO0 packet
    cyc("R5", 0, 0, 6'h15, 6'h3F, 0);
    chk("R5 low fallback", 32'(grant), 32'h04);
    cyc("R5", 0, 0, 6'h15, 6'h3F, 1);
    cyc("R5", 0, 0, 6'h15, 6'h3F, 0);
    chk("R5 low rotate", 32'(grant), 32'h10);
    cyc("R5", 0, 0, 6'h15, 6'h3F, 1);
    cyc("R5", 0, 0, 6'h15, 6'h3F, 0);
    chk("R5 low wrap", 32'(grant), 32'h01);
    cyc("R5", 0, 0, 6'h15, 6'h3F, 1);

    // R11: done while idle leaves low pointer at 1
    cyc("R11", 0, 0, 6'h00, 6'h3F, 1);
    chk("R11 idle done", 32'(grant), 32'h00);
    cyc("R11", 0, 0, 6'h15, 6'h3F, 0);
    chk("R11 pointer kept", 32'(grant), 32'h04);
    cyc("R11", 0, 0, 6'h00, 6'h3F, 1);

    // R10: priority rewritten during a high-tier packet
    cyc("R10", 0, 0, 6'h02, 6'h3F, 0);
    chk("R10 start", 32'(grant), 32'h02);
    cyc("R10", 1, 32'h0, 6'h3F, 6'h3F, 0);
    chk("R10 grant kept after write", 32'(grant), 32'h02);
    cyc("R10", 0, 0, 6'h3F, 6'h3F, 1);
    cyc("R10", 0, 0, 6'h3F, 6'h3F, 0);
    chk("R10 low ptr untouched", 32'(grant), 32'h08);
    cyc("R10", 0, 0, 6'h3F, 6'h3F, 1);
    cyc("R9", 0, 0, 6'h00, 6'h00, 0);
    chk("R9 nothing eligible", 32'(grant_valid), 32'h0);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      bit we;
      we = ($urandom % 16) == 0;
      cyc("R9 random", we, $urandom, 6'($urandom), 6'($urandom | $urandom),
          ($urandom % 4) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule